// File: doc/BRIEF.md
# One-Shot Pulse Width Capture

This block measures the width of a single active-high pulse and then holds the result. The pulse input is synchronized into the system clock domain and checked for rising and falling edges. A rising edge sets a start flag. A falling edge copies the start flag into a done flag. The accumulator adds a programmable step on every clock cycle in which the start flag is set and the done flag is clear. Once the done flag is set, counting stops and the width, the done flag and the overflow flag stay frozen. Later pulses change none of them.

To take a new measurement, software pulses a re-arm request. A short sequencer then applies its clears in a fixed order. First it clears the start flag. Then it clears the done flag and the accumulator. Then it releases the done flag. Last, it releases the start flag. While the done flag is released, the start flag is still held low, so a falling edge during the sequence cannot set the done flag. A pulse that is already high when the sequence ends is not measured, because counting begins only on a fresh rising edge.

Top module: `pulse_snap`

## Requirements
- R1: After reset, `width` is 0, `done` is 0 and `ovf` is 0. Nothing is counted until a rising edge of `pulse_in` is seen.
- R2: A pulse whose input is sampled high on N consecutive rising clock edges gives `width` = N × `step`. The uncertainty is minus zero, plus one clock.
- R3: `done` rises on the third rising clock edge, counting the first edge that samples `pulse_in` low. It then stays high until a re-arm.
- R4: After `done` is set, further pulses and changes to `step` leave `width`, `done` and `ovf` unchanged.
- R5: If the exact sum would exceed 2^ACC_W − 1, `width` saturates at all ones and `ovf` is set. `ovf` is sticky until a re-arm. A sum equal to exactly 2^ACC_W − 1 does not set `ovf`.
- R6: A one-cycle `rearm` pulse starts a four-step sequence in this order: clear start, clear done, release done, release start. At its end, `width`, `done` and `ovf` are 0. A `rearm` that arrives while the sequence is running is ignored.
- R7: A pulse that is high during the re-arm sequence is not measured. Its falling edge leaves `done` at 0 and `width` at 0. The next complete pulse is measured normally.
- R8: While no measurement is in progress, `width` does not change, except when the re-arm sequence clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous pulse to be measured (active high) |
| rearm | input | 1 | One-cycle request to start the re-arm sequence |
| step | input | ACC_W | Amount added to the accumulator per counted cycle |
| width | output | ACC_W | Captured pulse width in step units, saturating |
| done | output | 1 | Measurement complete; result is frozen |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach is a re-arm that overlaps a pulse already high. Here the falling edge arrives after the sequence has released the done flag but while the start flag is still clear or was never set. The bench raises the pulse, issues the re-arm in the middle of it, and drops the pulse some cycles later. It then checks that no result appears, and that a following full pulse is captured exactly. The saturation boundary is reached by choosing steps that land exactly on full scale or one step past it. Random widths and steps then cover the ordinary range.

// File: rtl/pulse_snap.sv
module pulse_snap #(
  parameter int ACC_W  = 20,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             rearm,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] width,
  output logic             done,
  output logic             ovf
);

  localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

  typedef enum logic [1:0] {IDLE, HOLD_A, HOLD_AB, REL_B} seq_t;

  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;
  logic              pin, rise, fall;
  logic              start_q;
  seq_t              seq_q;
  logic              clr_start, clr_done;
  logic              cnt_en;
  logic [ACC_W:0]    sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pulse_in};
      prev_q <= pin;
    end
  end

  assign pin  = sync_q[SYNC_N-1];
  assign rise = pin & ~prev_q;
  assign fall = ~pin & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seq_q <= IDLE;
    else begin
      case (seq_q)
        IDLE:    if (rearm) seq_q <= HOLD_A;
        HOLD_A:  seq_q <= HOLD_AB;
        HOLD_AB: seq_q <= REL_B;
        default: seq_q <= IDLE;
      endcase
    end
  end

  assign clr_start = (seq_q != IDLE);
  assign clr_done  = (seq_q == HOLD_AB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         start_q <= 1'b0;
    else if (clr_start) start_q <= 1'b0;
    else if (rise)      start_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done <= 1'b0;
    else if (clr_done) done <= 1'b0;
    else if (fall)     done <= start_q;
  end

  assign cnt_en = start_q & ~done;
  assign sum    = {1'b0, width} + {1'b0, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width <= '0;
      ovf   <= 1'b0;
    end else if (clr_done) begin
      width <= '0;
      ovf   <= 1'b0;
    end else if (cnt_en) begin
      if (sum[ACC_W]) begin
        width <= FULL;
        ovf   <= 1'b1;
      end else begin
        width <= sum[ACC_W-1:0];
      end
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr_done) |=> $stable(width));

  // R3
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr_done) |=> done);

  // R7
  done_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start_q));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_done) |=> (ovf && width == FULL));

  // R6
  clear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |-> (clr_start && $past(clr_start)));

  // R6
  release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_done) |-> clr_start);

  // R2
  no_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_done |=> (width >= $past(width)));

endmodule

// File: tb/pulse_snap_test.sv
module pulse_snap_test;
  localparam int W = 20;
  localparam longint MAXV = (64'd1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pulse_in = 1'b0;
  logic         rearm = 1'b0;
  logic [W-1:0] step = '0;
  logic [W-1:0] width;
  logic         done, ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  pulse_snap #(.ACC_W(W), .SYNC_N(2)) uut (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .rearm(rearm),
    .step(step), .width(width), .done(done), .ovf(ovf));

  always #4 clk = ~clk;

  function automatic longint exp_width(input int n, input longint s);
    longint p = longint'(n) * s;
    return (p > MAXV) ? MAXV : p;
  endfunction

  function automatic bit exp_ovf(input int n, input longint s);
    return (longint'(n) * s) > MAXV;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_rearm();
    rearm = 1'b1;
    cyc(1);
    rearm = 1'b0;
    cyc(6);
  endtask

  // Pulse high for n sampling edges; checks done latency (R3).
  task automatic do_pulse(input int n, input bit chk_lat);
    pulse_in = 1'b1;
    cyc(n);
    pulse_in = 1'b0;
    cyc(2);
    if (chk_lat) check("R3 done before third edge", done, 0);
    cyc(1);
    if (chk_lat) check("R3 done at third edge", done, 1);
    cyc(3);
  endtask

  task automatic measure(input int n, input longint s, input string req);
    step = s[W-1:0];
    do_rearm();
    check({req, " cleared width"}, width, 0);
    do_pulse(n, 1'b1);
    check({req, " width"}, width, exp_width(n, s));
    check("R5 ovf", ovf, exp_ovf(n, s));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint w1;
    void'($urandom(32'd4711));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1
    check("R1 width", width, 0);
    check("R1 done", done, 0);
    check("R1 ovf", ovf, 0);
    step = 20'd3;
    cyc(10);
    check("R1 no count without edge", width, 0);

    // R2 first measurement straight from reset, minimum pulse
    do_pulse(1, 1'b1);
    check("R2 one-cycle pulse", width, 3);

    // R4 later pulse and step change ignored
    step = 20'd100;
    do_pulse(7, 1'b0);
    check("R4 width frozen", width, 3);
    check("R4 done held", done, 1);

    // R6 re-arm clears, and a second rearm during the sequence is ignored
    rearm = 1'b1; cyc(1); rearm = 1'b0;
    cyc(1); rearm = 1'b1; cyc(1); rearm = 1'b0;
    cyc(5);
    check("R6 width cleared", width, 0);
    check("R6 done cleared", done, 0);
    do_pulse(4, 1'b1);
    check("R6 next capture", width, 400);

    // R5 exact full scale, then one past
    measure(1, MAXV, "R5 exact");
    check("R5 exact no ovf", ovf, 0);
    measure(2, MAXV, "R5 over");
    measure(5, 64'h40000, "R5 over2");
    do_rearm();
    check("R6 ovf cleared", ovf, 0);

    // R7 pulse high across the re-arm sequence
    step = 20'd1;
    pulse_in = 1'b1;
    cyc(5);
    do_rearm();
    cyc(4);
    pulse_in = 1'b0;
    cyc(6);
    check("R7 no done", done, 0);
    check("R7 no width", width, 0);
    do_pulse(9, 1'b1);
    check("R7 next pulse", width, 9);

    // R8 armed but idle: width holds
    do_rearm();
    cyc(20);
    check("R8 idle width", width, 0);

    // Random widths and steps
    for (int k = 0; k < 30; k++) begin
      int n = 1 + ($urandom % 60);
      longint s = (k % 5 == 4) ? longint'($urandom % (1 << W))
                               : longint'(1 + ($urandom % 300));
      measure(n, s, "R2 random");
      if ($urandom % 2) begin
        w1 = width;
        step = $urandom;
        do_pulse(1 + ($urandom % 10), 1'b0);
        check("R4 random frozen", width, w1);
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule